// File: doc/BRIEF.md
# Single-Cycle Four-Instruction RISC Core

This block is a 32-bit processor core that retires one instruction on every rising clock edge. In one cycle the current program counter goes out as the instruction address, and the returned word is decoded. Up to two registers are read, an adder or a signed comparator does the work, the data memory is read or written if the instruction needs it, and the result is committed to the register file on the closing edge. The clock period must be long enough for the slowest path, which is a load. That path runs through the register read, the address adder, the data-memory read and the write-back multiplexer.

The core recognises four operations: register-register add, set-if-less-than against a signed immediate, load word and store word. Each operation uses only the stages it needs. A store leaves the register file untouched. Add and set-less-than never touch data memory. Any other encoding only advances the program counter. Both memories sit outside the block and answer combinationally within the cycle. `rst_n` is asynchronous, active low, and must be deasserted synchronously to `clk`.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, `imem_addr` is 0 and `dmem_we` is 0. The first instruction after reset is fetched from address 0.
- R2: Each rising clock edge with `rst_n` high advances `imem_addr` by exactly 4, whatever instruction was fetched.
- R3: An add (bits [31:26]=0x00, [10:6]=0, [5:0]=0x20) writes rs+rt into rd, where rs is bits [25:21], rt is bits [20:16] and rd is bits [15:11]. It keeps `dmem_we` low.
- R4: A set-less-than-immediate (opcode 0x0A) writes 1 into rt when rs is less than the immediate as signed 32-bit values, and 0 otherwise. It keeps `dmem_we` low.
- R5: A load (opcode 0x23) drives `dmem_addr` with rs plus the immediate, keeps `dmem_we` low, and writes `dmem_rdata` into rt.
- R6: A store (opcode 0x2B) drives `dmem_addr` with rs plus the immediate, `dmem_wdata` with the value of rt, and `dmem_we` high. It changes no register.
- R7: Register 0 always reads as zero, and results aimed at it are discarded.
- R8: Any other opcode, and an opcode-0 word that is not a well-formed add, changes no register and keeps `dmem_we` low.
- R9: The 16-bit immediate (bits [15:0]) is sign-extended, so negative offsets and negative compare values behave as signed.
- R10: Add results wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; every instruction completes on one rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| imem_addr | output | 32 | Byte address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word returned for `imem_addr` in the same cycle |
| dmem_addr | output | 32 | Word-aligned byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe; memory captures `dmem_wdata` on the rising edge |
| dmem_rdata | input | 32 | Load data returned for `dmem_addr` in the same cycle |

## Verification
The register file has no port of its own, so its contents can only be seen when a store carries a register onto `dmem_wdata`. Every sum, comparison result and loaded word is therefore moved out by a following store. The same route shows that stores, register-0 targets and unrecognised encodings left a register unchanged. To reach the arithmetic corners (signed overflow, wrap to zero, the most negative immediate), the bench first loads a set of extreme operands from data memory into eight registers. It then sweeps every ordered register pair through the adder and every register through a set of boundary immediates in the comparator.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  localparam int INSN_W = 32;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_SLTI  = 6'h0A;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;
  localparam logic [5:0] FN_ADD    = 6'h20;

  typedef enum logic {
    ALU_ADD = 1'b0,
    ALU_SLT = 1'b1
  } alu_op_e;

  // datapath steering produced by the decoder
  typedef struct packed {
    logic    rf_we;    // commit a result to the register file
    logic    dm_we;    // strobe data memory
    logic    opb_imm;  // ALU operand B from immediate
    logic    wb_mem;   // write-back from memory instead of ALU
    logic    dst_rd;   // destination from rd field instead of rt
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/sc_pc_unit.sv
module sc_pc_unit #(
  parameter int          W        = 32,
  parameter logic [31:0] RESET_PC = 32'h0,
  parameter int          STEP     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_en,
  output logic [W-1:0] pc_q
);

  logic [W-1:0] pc_d;

  always_comb begin
    pc_d = pc_q;
    if (adv_en) pc_d = pc_q + W'(STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= W'(RESET_PC);
    else        pc_q <= pc_d;
  end

  // R2: one fetch step per cycle out of reset
  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en |=> pc_q == $past(pc_q) + W'(STEP));

endmodule

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_core_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [INSN_W-1:0] insn,
  output ctrl_t             ctl,
  output logic [4:0]        rs_f,
  output logic [4:0]        rt_f,
  output logic [4:0]        rd_f,
  output logic [W-1:0]      imm_ext
);

  logic [5:0]  opc;
  logic [4:0]  shamt;
  logic [5:0]  funct;
  logic [15:0] imm16;

  always_comb begin
    opc   = insn[31:26];
    rs_f  = insn[25:21];
    rt_f  = insn[20:16];
    rd_f  = insn[15:11];
    shamt = insn[10:6];
    funct = insn[5:0];
    imm16 = insn[15:0];
  end

  // R9: sign extension of the 16-bit field
  always_comb imm_ext = {{(W-16){imm16[15]}}, imm16};

  always_comb begin
    ctl = '{rf_we: 1'b0, dm_we: 1'b0, opb_imm: 1'b0, wb_mem: 1'b0,
            dst_rd: 1'b0, alu_op: ALU_ADD};
    unique case (opc)
      OPC_RTYPE: begin
        if (funct == FN_ADD && shamt == 5'd0) begin
          ctl.rf_we  = 1'b1;
          ctl.dst_rd = 1'b1;
        end
      end
      OPC_SLTI: begin
        ctl.rf_we   = 1'b1;
        ctl.opb_imm = 1'b1;
        ctl.alu_op  = ALU_SLT;
      end
      OPC_LW: begin
        ctl.rf_we   = 1'b1;
        ctl.opb_imm = 1'b1;
        ctl.wb_mem  = 1'b1;
      end
      OPC_SW: begin
        ctl.dm_we   = 1'b1;
        ctl.opb_imm = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);

  logic [W-1:0] regs_q [NREG];
  logic         wr_en;

  // R7: entry 0 is never written
  always_comb wr_en = we && (wa != '0);

  always_ff @(posedge clk) begin
    if (wr_en) regs_q[wa] <= wd;
  end

  always_comb begin
    rd_a = (ra_a == '0) ? '0 : regs_q[ra_a];
    rd_b = (ra_b == '0) ? '0 : regs_q[ra_b];
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  logic [W-1:0] sum;
  logic         lt;

  always_comb begin
    sum = a + b;                          // R10: modulo 2^W
    lt  = $signed(a) < $signed(b);        // R4: signed compare
    unique case (op)
      ALU_ADD: y = sum;
      ALU_SLT: y = {{(W-1){1'b0}}, lt};
      default: y = sum;
    endcase
  end

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          NREG     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);

  localparam int AW       = $clog2(NREG);
  localparam int PC_STEP  = INSN_W / 8;

  ctrl_t           ctl;
  logic [4:0]      rs_f, rt_f, rd_f;
  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] rs_val, rt_val;
  logic [XLEN-1:0] opb, alu_y, wb_data;
  logic [AW-1:0]   wa;
  logic            rf_we;
  logic [XLEN-1:0] pc_q;

  // fetch
  sc_pc_unit #(.W(XLEN), .RESET_PC(RESET_PC), .STEP(PC_STEP)) u_pc (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_en (1'b1),
    .pc_q   (pc_q)
  );

  always_comb imem_addr = pc_q;

  // decode
  sc_decoder #(.W(XLEN)) u_dec (
    .insn    (imem_rdata),
    .ctl     (ctl),
    .rs_f    (rs_f),
    .rt_f    (rt_f),
    .rd_f    (rd_f),
    .imm_ext (imm_ext)
  );

  // register read / write-back
  always_comb begin
    wa      = ctl.dst_rd ? rd_f[AW-1:0] : rt_f[AW-1:0];
    wb_data = ctl.wb_mem ? dmem_rdata : alu_y;
    rf_we   = ctl.rf_we & rst_n;
  end

  sc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk  (clk),
    .ra_a (rs_f[AW-1:0]),
    .ra_b (rt_f[AW-1:0]),
    .rd_a (rs_val),
    .rd_b (rt_val),
    .we   (rf_we),
    .wa   (wa),
    .wd   (wb_data)
  );

  // execute
  always_comb opb = ctl.opb_imm ? imm_ext : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .op (ctl.alu_op),
    .a  (rs_val),
    .b  (opb),
    .y  (alu_y)
  );

  // memory
  always_comb begin
    dmem_addr  = alu_y;
    dmem_wdata = rt_val;
    dmem_we    = ctl.dm_we & rst_n;
  end

  // R6: a store never commits to the register file
  a_r6_store_no_rf_write: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> !rf_we);

  // R4: the compare path writes back a single bit
  a_r4_slt_bool: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_rdata[31:26] == OPC_SLTI) |-> (wb_data[XLEN-1:1] == '0 && !dmem_we));

  // R3: register add leaves data memory alone
  a_r3_add_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_rdata[31:26] == OPC_RTYPE) |-> !dmem_we);

  // R8: unrecognised opcodes are silent
  a_r8_unknown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_rdata[31:26] != OPC_RTYPE && imem_rdata[31:26] != OPC_SLTI &&
     imem_rdata[31:26] != OPC_LW && imem_rdata[31:26] != OPC_SW)
    |-> (!dmem_we && !rf_we));

  // R5: a load reads through to the register file
  a_r5_load_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_rdata[31:26] == OPC_LW && imem_rdata[20:16] != 5'd0)
    |-> (rf_we && wb_data == dmem_rdata && !dmem_we));

endmodule

// File: tb/sc_core_tb.sv
module sc_core_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [31:0] imem_addr, imem_rdata;
  logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [31:0] dmem [64];
  logic [31:0] rf   [32];

  always #5 clk = ~clk;

  sc_core u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_add(input int rs, input int rt, input int rd);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'h20};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                        input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] seed_val(input int k);
    case (k)
      1: return 32'h0000_0000;
      2: return 32'h0000_0001;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      5: return 32'hFFFF_FFFF;
      9: return 32'h0000_0040;
      default: return (32'(k) * 32'h9E37_79B9) ^ 32'h0BAD_F00D;
    endcase
  endfunction

  // Issue one instruction, check its memory-side effects and the PC step,
  // then update the reference register model.
  task automatic step(input logic [31:0] ins, input string tag);
    logic [5:0]  op;
    int          rs, rt, rd;
    logic [31:0] imm, addr, pc0, ld;
    logic        is_add;
    op  = ins[31:26];
    rs  = int'(ins[25:21]);
    rt  = int'(ins[20:16]);
    rd  = int'(ins[15:11]);
    imm = {{16{ins[15]}}, ins[15:0]};
    is_add = (op == 6'h00) && (ins[10:6] == 5'd0) && (ins[5:0] == 6'h20);
    addr = rf[rs] + imm;
    imem_rdata = ins;
    #1;
    pc0 = imem_addr;
    ld  = dmem[addr[7:2]];
    case (op)
      6'h2B: begin
        check({tag, " R6 store strobe"}, 32'(dmem_we), 32'd1);
        check({tag, " R6 store address"}, dmem_addr, addr);
        check({tag, " R6 store data"}, dmem_wdata, rf[rt]);
      end
      6'h23: begin
        check({tag, " R5 load address"}, dmem_addr, addr);
        check({tag, " R5 load no strobe"}, 32'(dmem_we), 32'd0);
      end
      6'h0A: check({tag, " R4 slti no strobe"}, 32'(dmem_we), 32'd0);
      6'h00: check({tag, " R3/R8 opcode-0 no strobe"}, 32'(dmem_we), 32'd0);
      default: check({tag, " R8 unknown no strobe"}, 32'(dmem_we), 32'd0);
    endcase
    @(posedge clk);
    @(negedge clk);
    check({tag, " R2 pc step"}, imem_addr, pc0 + 32'd4);
    if (op == 6'h00 && is_add) rf[rd] = rf[rs] + rf[rt];
    else if (op == 6'h0A) rf[rt] = ($signed(rf[rs]) < $signed(imm)) ? 32'd1 : 32'd0;
    else if (op == 6'h23) rf[rt] = ld;
    rf[0] = 32'd0;
  endtask

  initial begin
    #(200_000 * 10);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] imms [6];
    imms[0] = 16'h0000; imms[1] = 16'h0001; imms[2] = 16'hFFFF;
    imms[3] = 16'h7FFF; imms[4] = 16'h8000; imms[5] = 16'h0005;
    for (int k = 0; k < 64; k++) dmem[k] = seed_val(k);
    for (int k = 0; k < 32; k++) rf[k] = 32'd0;
    imem_rdata = 32'h0;

    // R1: reset state
    #3 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset pc", imem_addr, 32'd0);
    imem_rdata = enc_i(6'h2B, 0, 0, 16'h0010);
    #1;
    check("R1 reset store suppressed", 32'(dmem_we), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 first fetch at zero", imem_addr, 32'd0);
    imem_rdata = 32'h0;
    @(negedge clk);

    // R5: fill r1..r9 from data memory
    for (int k = 1; k <= 9; k++) step(enc_i(6'h23, 0, k, 16'(4 * k)), "fill");
    for (int k = 1; k <= 9; k++) begin
      step(enc_i(6'h2B, 0, k, 16'h0080), "R5 readback");
    end

    // R9: negative offsets from a base held in r9 (=64)
    step(enc_i(6'h23, 9, 12, 16'hFFE0), "R9 load -32");
    step(enc_i(6'h2B, 0, 12, 16'h0084), "R9 loaded value");
    step(enc_i(6'h2B, 9, 5, 16'hFFF8), "R9 store -8");

    // R3/R10: every ordered pair of r0..r8 through the adder
    for (int i = 0; i <= 8; i++) begin
      for (int j = 0; j <= 8; j++) begin
        step(enc_add(i, j, 20), "R3 add");
        step(enc_i(6'h2B, 0, 20, 16'h0088), "R3/R10 sum");
      end
    end

    // R4/R9: each register against boundary immediates
    for (int i = 0; i <= 8; i++) begin
      for (int m = 0; m < 6; m++) begin
        step(enc_i(6'h0A, i, 21, imms[m]), "R4 slti");
        step(enc_i(6'h2B, 0, 21, 16'h008C), "R4 compare result");
      end
    end

    // R7: results aimed at register 0 vanish
    step(enc_add(3, 2, 0), "R7 add to r0");
    step(enc_i(6'h2B, 0, 0, 16'h0090), "R7 r0 after add");
    step(enc_i(6'h23, 0, 0, 16'h000C), "R7 load to r0");
    step(enc_i(6'h2B, 0, 0, 16'h0090), "R7 r0 after load");

    // R6: a store leaves its data register unchanged
    step(enc_i(6'h2B, 0, 3, 16'h0094), "R6 first store");
    step(enc_i(6'h2B, 0, 3, 16'h0098), "R6 register kept");

    // R8: unknown opcode and malformed opcode-0 words
    step(enc_i(6'h3F, 1, 4, 16'h1234), "R8 opcode 3F");
    step(enc_i(6'h2B, 0, 4, 16'h009C), "R8 r4 kept");
    step({6'h00, 5'd2, 5'd3, 5'd5, 5'd0, 6'h22}, "R8 funct 22");
    step(enc_i(6'h2B, 0, 5, 16'h00A0), "R8 r5 kept");
    step({6'h00, 5'd2, 5'd3, 5'd6, 5'd1, 6'h20}, "R8 shamt set");
    step(enc_i(6'h2B, 0, 6, 16'h00A4), "R8 r6 kept");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule